// File: doc/BRIEF.md
# Pixel Colour Component Extractor

This block turns one raw pixel word from a display pixel stream into three colour outputs of 8 bits each: red, green and blue. A select word for each colour tells the block where the colour field starts in the pixel (its lowest bit), how many bits the field has, and which fallback value to send when no real pixel data should appear. The same block therefore serves 16-bit 5-6-5 pixels, packed 24-bit pixels and 32-bit pixels that carry alpha in their lowest byte. Only the select words change between these layouts.

The fallback value takes the place of the extracted field in three cases: the pixel lies outside the visible area, the pixel source has underrun and has no valid word, or the select word asks for a zero-bit field. A field narrower than 8 bits is placed at the top of the output byte. Its upper bits are copied into the bits below it, so that full scale maps to 0xFF. All outputs come from one pipeline register. A data enable output follows the active-area input with the same delay of one cycle.

Top module: `pix_comp_extract`

## Requirements
- R1: In each select word, bits 23:16 hold the fallback component value, bits 11:8 hold the field width and bits 4:0 hold the offset of the field's lowest bit. Bits 31:24, 15:12 and 7:5 have no effect.
- R2: The extracted field is pixel bits [offset+width-1 : offset]. Positions above bit 31 read as zero.
- R3: A field of width w < 8 appears left-aligned in the 8-bit output, and its bits repeat downward to fill the low bits (5-bit v gives {v, v[4:2]}; 3-bit v gives {v, v, v[2:1]}).
- R4: A width value larger than 8 acts as width 8.
- R5: A width value of zero makes that channel output its fallback value.
- R6: While active_i is 0, all three channels output their fallback values.
- R7: While pix_valid_i is 0 (underrun), all three channels output their fallback values.
- R8: Colour outputs and de_o change exactly one clock after their inputs. de_o equals active_i delayed by one cycle.
- R9: While rst_n is low, all colour outputs and de_o are zero.
- R10: Three layouts decode correctly with the right select words: 5-6-5 (blue 0/5, green 5/6, red 11/5 as offset/width), 8-8-8 (blue 0, green 8, red 16) and alpha-low 32-bit (blue 8, green 16, red 24).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_i | input | 32 | Raw pixel word |
| pix_valid_i | input | 1 | Pixel word valid; 0 marks an underrun |
| active_i | input | 1 | Pixel lies in the visible area |
| sel_red_i | input | 32 | Red select word (fallback, width, offset) |
| sel_grn_i | input | 32 | Green select word |
| sel_blu_i | input | 32 | Blue select word |
| red_o | output | 8 | Red component, registered |
| grn_o | output | 8 | Green component, registered |
| blu_o | output | 8 | Blue component, registered |
| de_o | output | 1 | Data enable, active_i delayed by one cycle |

## Verification
Each colour result and de_o is due exactly one rising edge after its inputs are applied. The bench drives a new pixel, new select words and new qualifiers on a falling edge and reads the outputs on the next falling edge, so exactly one register stage lies between stimulus and sample. For the latency requirement, the bench also samples once just after driving and before the rising edge, and there it expects the previous values to be still present. Reset is checked while rst_n is held low, with the pixel inputs driven high.

// File: rtl/pce_pkg.sv
package pce_pkg;
   // Select word field positions (a neighbouring register block writes these)
   localparam int SEL_W    = 32;
   localparam int DFLT_LSB = 16;
   localparam int DFLT_W   = 8;
   localparam int WID_LSB  = 8;
   localparam int WID_W    = 4;
   localparam int OFS_LSB  = 0;
   localparam int OFS_W    = 5;

   // Channel order inside the packed component vectors
   localparam int NUM_CH   = 3;
   localparam int CH_RED   = 0;
   localparam int CH_GRN   = 1;
   localparam int CH_BLU   = 2;
endpackage

// File: rtl/pce_field_extract.sv
module pce_field_extract #(
   parameter int PIX_W     = 32,
   parameter int COMP_W    = 8,
   parameter int WID_W     = 4,
   parameter int OFS_W     = 5,
   parameter bit REPLICATE = 1'b1
) (
   input  logic [PIX_W-1:0]  pix_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic [WID_W-1:0]  wid_i,
   output logic [COMP_W-1:0] comp_o
);
   localparam logic [COMP_W-1:0] ONES     = '1;
   localparam logic [WID_W-1:0]  WID_FULL = WID_W'(COMP_W);

   logic [COMP_W-1:0] low_bits;
   logic [WID_W-1:0]  wid_eff;
   logic [WID_W-1:0]  lift;
   logic [COMP_W-1:0] field;
   logic [COMP_W-1:0] aligned;

   // R2: shift zeros in above the top of the pixel word
   assign low_bits = COMP_W'(pix_i >> ofs_i);
   // R4: widths above the output size act as the full output size
   assign wid_eff  = (wid_i > WID_FULL) ? WID_FULL : wid_i;
   assign field    = low_bits & ~(ONES << wid_eff);
   assign lift     = WID_FULL - wid_eff;
   assign aligned  = field << lift;

   generate
      if (REPLICATE) begin : g_repl
         // R3: copy the field downward until the low bits are filled
         logic [COMP_W-1:0] acc;
         logic [COMP_W-1:0] tmp;
         always_comb begin
            acc = '0;
            tmp = aligned;
            for (int j = 0; j < COMP_W; j++) begin
               acc = acc | tmp;
               tmp = tmp >> wid_eff;
            end
         end
         assign comp_o = acc;
      end else begin : g_zero
         assign comp_o = aligned;
      end
   endgenerate
endmodule

// File: rtl/pce_out_reg.sv
module pce_out_reg #(
   parameter int COMP_W = 8,
   parameter int NUM_CH = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_CH-1:0][COMP_W-1:0]  comp_d,
   input  logic                           de_d,
   output logic [NUM_CH-1:0][COMP_W-1:0]  comp_q,
   output logic                           de_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         comp_q <= '0;
         de_q   <= 1'b0;
      end else begin
         comp_q <= comp_d;
         de_q   <= de_d;
      end
   end

   // R9: a reset cycle leaves everything cleared
   p_reset_clear_r9: assert property (@(posedge clk)
      !rst_n |=> (comp_q == '0) && !de_q);
endmodule

// File: rtl/pix_comp_extract.sv
module pix_comp_extract
   import pce_pkg::*;
#(
   parameter int PIX_W     = 32,
   parameter int COMP_W    = 8,
   parameter bit REPLICATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  pix_i,
   input  logic              pix_valid_i,
   input  logic              active_i,
   input  logic [SEL_W-1:0]  sel_red_i,
   input  logic [SEL_W-1:0]  sel_grn_i,
   input  logic [SEL_W-1:0]  sel_blu_i,
   output logic [COMP_W-1:0] red_o,
   output logic [COMP_W-1:0] grn_o,
   output logic [COMP_W-1:0] blu_o,
   output logic              de_o
);
   initial begin : elab_checks
      assert (PIX_W >= COMP_W && PIX_W <= (1 << OFS_W))
         else $error("PIX_W must lie between COMP_W and 2**OFS_W");
      assert (COMP_W >= 1 && COMP_W <= DFLT_W)
         else $error("COMP_W must fit the fallback field");
   end

   logic [SEL_W-1:0]               sel_a [NUM_CH];
   logic [NUM_CH-1:0][COMP_W-1:0]  comp_d;
   logic [NUM_CH-1:0][COMP_W-1:0]  comp_q;
   logic                           blank;

   assign sel_a[CH_RED] = sel_red_i;
   assign sel_a[CH_GRN] = sel_grn_i;
   assign sel_a[CH_BLU] = sel_blu_i;

   // R6, R7: outside the visible area or during underrun, every channel falls back
   assign blank = !active_i || !pix_valid_i;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic [COMP_W-1:0] dflt;
         logic [WID_W-1:0]  wid;
         logic [OFS_W-1:0]  ofs;
         logic [COMP_W-1:0] ext;
         logic              unused_sel_bits;

         // R1: field positions within the select word
         assign dflt = sel_a[ch][DFLT_LSB +: COMP_W];
         assign wid  = sel_a[ch][WID_LSB  +: WID_W];
         assign ofs  = sel_a[ch][OFS_LSB  +: OFS_W];
         assign unused_sel_bits = ^{sel_a[ch][SEL_W-1:DFLT_LSB+COMP_W],
                                    sel_a[ch][DFLT_LSB-1:WID_LSB+WID_W],
                                    sel_a[ch][WID_LSB-1:OFS_LSB+OFS_W]};

         pce_field_extract #(
            .PIX_W     (PIX_W),
            .COMP_W    (COMP_W),
            .WID_W     (WID_W),
            .OFS_W     (OFS_W),
            .REPLICATE (REPLICATE)
         ) u_ext (
            .pix_i  (pix_i),
            .ofs_i  (ofs),
            .wid_i  (wid),
            .comp_o (ext)
         );

         // R5: a zero-bit field also selects the fallback
         assign comp_d[ch] = (blank || (wid == '0)) ? dflt : ext;

         p_zero_wid_dflt_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_a[ch][WID_LSB +: WID_W] == '0)
               |=> comp_q[ch] == $past(sel_a[ch][DFLT_LSB +: COMP_W]));
      end
   endgenerate

   pce_out_reg #(
      .COMP_W (COMP_W),
      .NUM_CH (NUM_CH)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .comp_d (comp_d),
      .de_d   (active_i),
      .comp_q (comp_q),
      .de_q   (de_o)
   );

   assign red_o = comp_q[CH_RED];
   assign grn_o = comp_q[CH_GRN];
   assign blu_o = comp_q[CH_BLU];

   // R8: data enable follows the active flag one cycle later
   p_de_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |=> de_o);
   p_de_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> !de_o);

   // R6: blanked pixels carry the fallback values
   p_blank_dflt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |=> {red_o, grn_o, blu_o} ==
         $past({sel_red_i[DFLT_LSB +: COMP_W], sel_grn_i[DFLT_LSB +: COMP_W],
                sel_blu_i[DFLT_LSB +: COMP_W]}));

   // R7: underrun pixels carry the fallback values
   p_underrun_dflt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid_i |=> {red_o, grn_o, blu_o} ==
         $past({sel_red_i[DFLT_LSB +: COMP_W], sel_grn_i[DFLT_LSB +: COMP_W],
                sel_blu_i[DFLT_LSB +: COMP_W]}));
endmodule

// File: tb/tb_pix_comp_extract.sv
`timescale 1ns/1ps
module tb_pix_comp_extract;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pix_i = '0;
   logic        pix_valid_i = 1'b0;
   logic        active_i = 1'b0;
   logic [31:0] sel_red_i = '0, sel_grn_i = '0, sel_blu_i = '0;
   logic [7:0]  red_o, grn_o, blu_o;
   logic        de_o;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   pix_comp_extract dut (
      .clk(clk), .rst_n(rst_n), .pix_i(pix_i), .pix_valid_i(pix_valid_i),
      .active_i(active_i), .sel_red_i(sel_red_i), .sel_grn_i(sel_grn_i),
      .sel_blu_i(sel_blu_i), .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o),
      .de_o(de_o)
   );

   // Vector: pix, sel red, sel green, sel blue, expected red, green, blue
   localparam int NVEC = 6;
   localparam logic [151:0] VEC [NVEC] = '{
      {32'hA5A5B52D, 32'h0011050B, 32'h00220605, 32'h00330500, 8'hB5, 8'hA6, 8'h6B}, // R10 565, R3
      {32'h0000FFFF, 32'h0011050B, 32'h00220605, 32'h00330500, 8'hFF, 8'hFF, 8'hFF}, // R10 565 full
      {32'h00000000, 32'h0011050B, 32'h00220605, 32'h00330500, 8'h00, 8'h00, 8'h00}, // R10 565 zero
      {32'hEE123456, 32'h00110810, 32'h00220808, 32'h00330800, 8'h12, 8'h34, 8'h56}, // R10 888
      {32'h89ABCDEF, 32'h00110818, 32'h00220810, 32'h00330808, 8'h89, 8'hAB, 8'hCD}, // R10 alpha-low
      {32'h00123456, 32'hFF11F8F0, 32'hAA22F8E8, 32'h5533F8E0, 8'h12, 8'h34, 8'h56}  // R1 junk bits
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] p, input logic [31:0] sr, input logic [31:0] sg,
                        input logic [31:0] sb, input logic act, input logic vld);
      @(negedge clk);
      pix_i = p; sel_red_i = sr; sel_grn_i = sg; sel_blu_i = sb;
      active_i = act; pix_valid_i = vld;
      @(negedge clk);
   endtask

   task automatic chk_rgb(input string tag, input logic [7:0] r, input logic [7:0] g,
                          input logic [7:0] b, input logic de);
      chk({tag, " red"}, {24'h0, red_o}, {24'h0, r});
      chk({tag, " green"}, {24'h0, grn_o}, {24'h0, g});
      chk({tag, " blue"}, {24'h0, blu_o}, {24'h0, b});
      chk({tag, " de"}, {31'h0, de_o}, {31'h0, de});
   endtask

   task automatic summary;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      summary();
   end

   initial begin : main
      // R9: reset with busy inputs
      pix_i = 32'hFFFFFFFF; active_i = 1'b1; pix_valid_i = 1'b1;
      sel_red_i = 32'h00110810; sel_grn_i = 32'h00220808; sel_blu_i = 32'h00330800;
      repeat (3) @(negedge clk);
      chk_rgb("R9 reset", 8'h00, 8'h00, 8'h00, 1'b0);
      rst_n = 1'b1;

      // Table walk: R10 layouts, R1 ignored bits, R3 replication
      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i][151:120], VEC[i][119:88], VEC[i][87:56], VEC[i][55:24], 1'b1, 1'b1);
         chk_rgb($sformatf("R10 vec%0d", i), VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], 1'b1);
      end

      // R8: new values must not appear before the rising edge
      @(negedge clk);
      pix_i = 32'h00ABCDEF; active_i = 1'b0;
      sel_red_i = 32'h00110810; sel_grn_i = 32'h00220808; sel_blu_i = 32'h00330800;
      #1;
      chk_rgb("R8 before edge", 8'h12, 8'h34, 8'h56, 1'b1);
      @(negedge clk);
      // R6: blanked pixel takes fallbacks, de low one cycle later
      chk_rgb("R6 blank", 8'h11, 8'h22, 8'h33, 1'b0);

      // R8: de returns one cycle after active
      drive(32'h00ABCDEF, 32'h00110810, 32'h00220808, 32'h00330800, 1'b1, 1'b1);
      chk_rgb("R8 after edge", 8'hAB, 8'hCD, 8'hEF, 1'b1);

      // R7: underrun inside the visible area
      drive(32'h00ABCDEF, 32'h00110810, 32'h00220808, 32'h00330800, 1'b1, 1'b0);
      chk_rgb("R7 underrun", 8'h11, 8'h22, 8'h33, 1'b1);

      // R5: zero width on green only
      drive(32'h00ABCDEF, 32'h00110810, 32'h00220008, 32'h00330800, 1'b1, 1'b1);
      chk_rgb("R5 zero width", 8'hAB, 8'h22, 8'hEF, 1'b1);

      // R4: width 12 on red at offset 4 behaves as width 8
      drive(32'h00000AB0, 32'h00110C04, 32'h00220808, 32'h00330800, 1'b1, 1'b1);
      chk("R4 clamp red", {24'h0, red_o}, 32'hAB);

      // R2: field runs past bit 31, upper part reads zero
      drive(32'hF0000000, 32'h0011081C, 32'h00220808, 32'h00330800, 1'b1, 1'b1);
      chk("R2 top edge red", {24'h0, red_o}, 32'h0F);

      // R3: 4-bit, 3-bit and 1-bit fields
      drive(32'h000000A5, 32'h00110404, 32'h00220300, 32'h00330107, 1'b1, 1'b1);
      chk("R3 width4 red", {24'h0, red_o}, 32'hAA);
      chk("R3 width3 green", {24'h0, grn_o}, 32'hB6);
      chk("R3 width1 blue", {24'h0, blu_o}, 32'hFF);
      drive(32'h0000007F, 32'h00110404, 32'h00220300, 32'h00330107, 1'b1, 1'b1);
      chk("R3 width1 blue zero", {24'h0, blu_o}, 32'h00);
      chk("R3 width4 red low", {24'h0, red_o}, 32'h77);

      summary();
   end
endmodule